// File: doc/BRIEF.md
# Voltage Readout Character Sequencer

This block turns a measured value, already split into three BCD digits, into the byte stream that a character display needs to show a voltage reading on its first line. On a readout request it captures the three digits and sends a cursor command to the start of line 1. It then sends a stored text label, the hundreds digit, a decimal point, the tens and ones digits, a space and a unit letter. A second request type sends a line-2 cursor command followed by a shorter stored label. A display write engine downstream takes the bytes.

Each output byte comes with a register-select flag: low marks a display command, high marks character data. Bytes leave through a registered valid/ready handshake, so the downstream engine can hold the stream for any number of cycles. One cycle after the final byte of a request is accepted, a single-cycle completion pulse is raised. Labels are held in a small zero-terminated character store. The terminator marks the end of a label and is never sent.

Top module: `vrs_readout_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it, `out_valid` and `done_pulse` are 0.
- R2: The first byte of a readout request is 0x80 with `out_rs` = 0. The first byte of a label request is 0xC0 with `out_rs` = 0.
- R3: Every byte after the first byte of a request is sent with `out_rs` = 1.
- R4: After its command, a readout request sends the label "Volts = " (8 characters) and a label request sends "Key = " (6 characters), one ASCII character per byte. The zero terminator of a stored label is never sent, so no sent byte is 0x00.
- R5: Each digit is sent as its BCD value plus 0x30 (digit 0 gives 0x30, digit 9 gives 0x39).
- R6: After the label, a readout request sends, in this order: hundreds digit, 0x2E ('.'), tens digit, ones digit, 0x20 (space), 0x56 ('V'). That makes 15 bytes in all. A label request ends after its label, with 7 bytes in all.
- R7: A label request (`start_key` high in an idle cycle) sends exactly the line-2 command and the "Key = " label, with no digits.
- R8: A byte is transferred only in a cycle in which `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_byte` and `out_rs` hold their values into the next cycle.
- R9: `done_pulse` is high for exactly one cycle: the cycle right after the last byte of a request is accepted. It is never high at any other time.
- R10: A request, of either type, that arrives while a sequence is in progress is ignored and produces no bytes. A sequence is in progress from the cycle after its request is sampled until its last byte is accepted. A request that arrives in the `done_pulse` cycle starts a new sequence.
- R11: The digits are captured in the cycle the readout request is sampled. Changes on the digit inputs after that do not alter the bytes sent.
- R12: If `start_volt` and `start_key` are both high in the same idle cycle, only the readout sequence is sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_volt | input | 1 | Request for the line-1 voltage readout |
| start_key | input | 1 | Request for the line-2 label |
| hun_digit | input | DIGIT_W | BCD hundreds digit |
| ten_digit | input | DIGIT_W | BCD tens digit |
| one_digit | input | DIGIT_W | BCD ones digit |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream ready to accept a byte |
| out_byte | output | 8 | Command or character byte |
| out_rs | output | 1 | Register select: 0 command, 1 data |
| done_pulse | output | 1 | One-cycle pulse after the last byte is accepted |

## Verification
The bench builds the block with its default parameters: 4-bit digits, a 0x30 ASCII offset and a 16-entry label store per request type. Both labels and their terminators fit in this store with room to spare, so the label walk, the terminator skip and the jump to the digit section are all covered. The downstream ready signal is driven either constantly high or from a pseudo-random pattern. The random pattern stalls the stream on the command byte, inside the label, and on the digits, the punctuation and the final unit byte. It also reaches the edge cases: both request inputs high in the same cycle, a request while a sequence is in progress, a request in the completion cycle, and digit inputs that change during a sequence.

// File: rtl/vrs_pkg.sv
package vrs_pkg;

  localparam int unsigned CHAR_W = 8;

  typedef enum logic [3:0] {
    PH_CMD,
    PH_LABEL,
    PH_HUN,
    PH_DOT,
    PH_TEN,
    PH_ONE,
    PH_SPACE,
    PH_UNIT,
    PH_END
  } phase_e;

  typedef enum logic {
    REQ_VOLT = 1'b0,
    REQ_KEY  = 1'b1
  } req_e;

  localparam logic [CHAR_W-1:0] CMD_LINE1 = 8'h80;
  localparam logic [CHAR_W-1:0] CMD_LINE2 = 8'hC0;
  localparam logic [CHAR_W-1:0] CH_POINT  = 8'h2E;
  localparam logic [CHAR_W-1:0] CH_BLANK  = 8'h20;
  localparam logic [CHAR_W-1:0] CH_UNIT   = 8'h56;

  // Stored label text; a zero marks the end of each label.
  function automatic logic [CHAR_W-1:0] label_char(input logic key_sel, input int unsigned idx);
    logic [CHAR_W-1:0] c;
    c = '0;
    if (!key_sel) begin
      case (idx)
        0: c = 8'h56;  // V
        1: c = 8'h6F;  // o
        2: c = 8'h6C;  // l
        3: c = 8'h74;  // t
        4: c = 8'h73;  // s
        5: c = 8'h20;  // space
        6: c = 8'h3D;  // =
        7: c = 8'h20;  // space
        default: c = '0;
      endcase
    end else begin
      case (idx)
        0: c = 8'h4B;  // K
        1: c = 8'h65;  // e
        2: c = 8'h79;  // y
        3: c = 8'h20;  // space
        4: c = 8'h3D;  // =
        5: c = 8'h20;  // space
        default: c = '0;
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/vrs_label_rom.sv
module vrs_label_rom
  import vrs_pkg::*;
#(
  parameter int unsigned LBL_AW = 4
) (
  input  req_e                    sel,
  input  logic [LBL_AW-1:0]       idx,
  output logic [CHAR_W-1:0]       char_cur,
  output logic [CHAR_W-1:0]       char_nxt
);

  localparam int unsigned LBL_DEPTH = 1 << LBL_AW;
  localparam logic [LBL_AW-1:0] IDX_MAX = LBL_AW'(LBL_DEPTH - 1);

  logic [CHAR_W-1:0] rom [0:1][0:LBL_DEPTH-1];

  for (genvar s = 0; s < 2; s++) begin : g_lbl
    for (genvar i = 0; i < LBL_DEPTH; i++) begin : g_ent
      assign rom[s][i] = label_char(s == 1, i);
    end
  end

  logic [LBL_AW-1:0] idx_inc;
  assign idx_inc  = idx + LBL_AW'(1);
  assign char_cur = rom[sel][idx];
  // Past the last entry the label is treated as terminated.
  assign char_nxt = (idx == IDX_MAX) ? '0 : rom[sel][idx_inc];

endmodule

// File: rtl/vrs_step_ctrl.sv
module vrs_step_ctrl
  import vrs_pkg::*;
#(
  parameter int unsigned       DIGIT_W   = 4,
  parameter int unsigned       LBL_AW    = 4,
  parameter logic [CHAR_W-1:0] ASCII_OFS = 8'h30
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_volt,
  input  logic                 start_key,
  input  logic [DIGIT_W-1:0]   hun_in,
  input  logic [DIGIT_W-1:0]   ten_in,
  input  logic [DIGIT_W-1:0]   one_in,
  input  logic                 out_busy,
  input  logic                 take,
  input  logic [CHAR_W-1:0]    lbl_cur,
  input  logic [CHAR_W-1:0]    lbl_nxt,
  output req_e                 lbl_sel,
  output logic [LBL_AW-1:0]    lbl_idx,
  output logic                 item_avail,
  output logic [CHAR_W-1:0]    item_byte,
  output logic                 item_rs,
  output logic                 item_last
);

  logic               active_q;
  req_e               mode_q;
  phase_e             phase_q;
  logic [LBL_AW-1:0]  ptr_q;
  logic [DIGIT_W-1:0] hun_q, ten_q, one_q;

  logic   idle;
  phase_e post_label;
  phase_e eff_phase;

  assign idle       = !active_q && !out_busy;
  assign post_label = (mode_q == REQ_VOLT) ? PH_HUN : PH_END;
  assign lbl_sel    = mode_q;
  assign lbl_idx    = ptr_q;

  // An empty label slot resolves straight to what follows the label.
  always_comb begin
    eff_phase = phase_q;
    if (phase_q == PH_LABEL && lbl_cur == '0) eff_phase = post_label;
  end

  always_comb begin
    item_byte = '0;
    item_rs   = 1'b1;
    item_last = 1'b0;
    case (eff_phase)
      PH_CMD: begin
        item_byte = (mode_q == REQ_VOLT) ? CMD_LINE1 : CMD_LINE2;
        item_rs   = 1'b0;
        item_last = (mode_q == REQ_KEY) && (lbl_cur == '0);
      end
      PH_LABEL: begin
        item_byte = lbl_cur;
        item_last = (mode_q == REQ_KEY) && (lbl_nxt == '0);
      end
      PH_HUN:   item_byte = ASCII_OFS + CHAR_W'(hun_q);
      PH_DOT:   item_byte = CH_POINT;
      PH_TEN:   item_byte = ASCII_OFS + CHAR_W'(ten_q);
      PH_ONE:   item_byte = ASCII_OFS + CHAR_W'(one_q);
      PH_SPACE: item_byte = CH_BLANK;
      PH_UNIT: begin
        item_byte = CH_UNIT;
        item_last = 1'b1;
      end
      default: item_byte = '0;
    endcase
  end

  assign item_avail = active_q && (eff_phase != PH_END);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      mode_q   <= REQ_VOLT;
      phase_q  <= PH_CMD;
      ptr_q    <= '0;
      hun_q    <= '0;
      ten_q    <= '0;
      one_q    <= '0;
    end else if (idle) begin
      if (start_volt || start_key) begin
        active_q <= 1'b1;
        mode_q   <= start_volt ? REQ_VOLT : REQ_KEY;
        phase_q  <= PH_CMD;
        ptr_q    <= '0;
        hun_q    <= hun_in;
        ten_q    <= ten_in;
        one_q    <= one_in;
      end
    end else if (take) begin
      if (item_last) begin
        active_q <= 1'b0;
        phase_q  <= PH_CMD;
        ptr_q    <= '0;
      end else begin
        case (eff_phase)
          PH_CMD: begin
            phase_q <= PH_LABEL;
            ptr_q   <= '0;
          end
          PH_LABEL: begin
            if (lbl_nxt == '0) phase_q <= post_label;
            else               ptr_q   <= ptr_q + LBL_AW'(1);
          end
          PH_HUN:   phase_q <= PH_DOT;
          PH_DOT:   phase_q <= PH_TEN;
          PH_TEN:   phase_q <= PH_ONE;
          PH_ONE:   phase_q <= PH_SPACE;
          PH_SPACE: phase_q <= PH_UNIT;
          default:  phase_q <= PH_END;
        endcase
      end
    end
  end

endmodule

// File: rtl/vrs_out_stage.sv
module vrs_out_stage
  import vrs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              item_avail,
  input  logic [CHAR_W-1:0] item_byte,
  input  logic              item_rs,
  input  logic              item_last,
  output logic              take,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CHAR_W-1:0] out_byte,
  output logic              out_rs,
  output logic              done_pulse
);

  logic last_q;
  logic accept;

  assign accept = out_valid && out_ready;
  assign take   = item_avail && (!out_valid || out_ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_byte   <= '0;
      out_rs     <= 1'b0;
      last_q     <= 1'b0;
      done_pulse <= 1'b0;
    end else begin
      done_pulse <= accept && last_q;
      if (take) begin
        out_valid <= 1'b1;
        out_byte  <= item_byte;
        out_rs    <= item_rs;
        last_q    <= item_last;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/vrs_readout_seq.sv
module vrs_readout_seq
  import vrs_pkg::*;
#(
  parameter int unsigned DIGIT_W   = 4,
  parameter int unsigned LBL_AW    = 4,
  parameter logic [7:0]  ASCII_OFS = 8'h30
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_volt,
  input  logic               start_key,
  input  logic [DIGIT_W-1:0] hun_digit,
  input  logic [DIGIT_W-1:0] ten_digit,
  input  logic [DIGIT_W-1:0] one_digit,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [7:0]         out_byte,
  output logic               out_rs,
  output logic               done_pulse
);

  req_e              lbl_sel;
  logic [LBL_AW-1:0] lbl_idx;
  logic [CHAR_W-1:0] lbl_cur, lbl_nxt;
  logic              item_avail, item_rs, item_last, take;
  logic [CHAR_W-1:0] item_byte;

  vrs_label_rom #(.LBL_AW(LBL_AW)) u_rom (
    .sel      (lbl_sel),
    .idx      (lbl_idx),
    .char_cur (lbl_cur),
    .char_nxt (lbl_nxt)
  );

  vrs_step_ctrl #(
    .DIGIT_W   (DIGIT_W),
    .LBL_AW    (LBL_AW),
    .ASCII_OFS (ASCII_OFS)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start_volt (start_volt),
    .start_key  (start_key),
    .hun_in     (hun_digit),
    .ten_in     (ten_digit),
    .one_in     (one_digit),
    .out_busy   (out_valid),
    .take       (take),
    .lbl_cur    (lbl_cur),
    .lbl_nxt    (lbl_nxt),
    .lbl_sel    (lbl_sel),
    .lbl_idx    (lbl_idx),
    .item_avail (item_avail),
    .item_byte  (item_byte),
    .item_rs    (item_rs),
    .item_last  (item_last)
  );

  vrs_out_stage u_out (
    .clk        (clk),
    .rst        (rst),
    .item_avail (item_avail),
    .item_byte  (item_byte),
    .item_rs    (item_rs),
    .item_last  (item_last),
    .take       (take),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_byte   (out_byte),
    .out_rs     (out_rs),
    .done_pulse (done_pulse)
  );

endmodule

// File: rtl/vrs_readout_seq_checker.sv
module vrs_readout_seq_checker #(
  parameter int unsigned DIGIT_W   = 4,
  parameter int unsigned LBL_AW    = 4,
  parameter logic [7:0]  ASCII_OFS = 8'h30
) (
  input logic               clk,
  input logic               rst,
  input logic               start_volt,
  input logic               start_key,
  input logic [DIGIT_W-1:0] hun_digit,
  input logic [DIGIT_W-1:0] ten_digit,
  input logic [DIGIT_W-1:0] one_digit,
  input logic               out_valid,
  input logic               out_ready,
  input logic [7:0]         out_byte,
  input logic               out_rs,
  input logic               done_pulse
);

  // Marks that the next byte to appear opens a new request.
  logic first_q;
  always_ff @(posedge clk) begin
    if (rst)                          first_q <= 1'b1;
    else if (done_pulse)              first_q <= 1'b1;
    else if (out_valid && out_ready)  first_q <= 1'b0;
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> !out_valid && !done_pulse);

  p_cmd_leads_r2: assert property (@(posedge clk) disable iff (rst)
    first_q && out_valid |-> !out_rs && (out_byte == 8'h80 || out_byte == 8'hC0));

  p_data_flag_r3: assert property (@(posedge clk) disable iff (rst)
    !first_q && out_valid |-> out_rs);

  p_no_terminator_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_byte != 8'h00);

  p_hold_stalled_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_byte) && $stable(out_rs));

  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    done_pulse |=> !done_pulse);

  p_done_after_accept_r9: assert property (@(posedge clk) disable iff (rst)
    done_pulse |-> $past(out_valid && out_ready));

endmodule

bind vrs_readout_seq vrs_readout_seq_checker #(
  .DIGIT_W   (DIGIT_W),
  .LBL_AW    (LBL_AW),
  .ASCII_OFS (ASCII_OFS)
) u_chk (.*);

// File: tb/vrs_readout_seq_bench.sv
module vrs_readout_seq_bench;

  localparam int WD_CYCLES = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_volt = 1'b0;
  logic       start_key = 1'b0;
  logic [3:0] hun_digit = '0, ten_digit = '0, one_digit = '0;
  logic       out_valid, out_ready, out_rs, done_pulse;
  logic [7:0] out_byte;

  always #4 clk = ~clk;  // 125 MHz

  vrs_readout_seq u_vrs_readout_seq (
    .clk(clk), .rst(rst), .start_volt(start_volt), .start_key(start_key),
    .hun_digit(hun_digit), .ten_digit(ten_digit), .one_digit(one_digit),
    .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
    .out_rs(out_rs), .done_pulse(done_pulse)
  );

  typedef struct {
    logic [7:0] b;
    logic       rs;
    logic       last;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  int   ready_mode = 0;
  logic [7:0] lfsr = 8'hA5;
  logic bench_done = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int got, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, expv);
    end
  endtask

  task automatic push(input logic [7:0] b, input logic rs, input logic last, input string tag);
    exp_t e;
    e.b = b; e.rs = rs; e.last = last; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // R2, R3, R4, R5, R6: expected readout stream
  task automatic push_volt(input int h, input int t, input int o);
    string lbl = "Volts = ";
    push(8'h80, 1'b0, 1'b0, "R2");
    for (int i = 0; i < lbl.len(); i++) push(lbl[i], 1'b1, 1'b0, "R4,R3");
    push(8'(8'h30 + h), 1'b1, 1'b0, "R5");
    push(8'h2E, 1'b1, 1'b0, "R6");
    push(8'(8'h30 + t), 1'b1, 1'b0, "R5");
    push(8'(8'h30 + o), 1'b1, 1'b0, "R5");
    push(8'h20, 1'b1, 1'b0, "R6");
    push(8'h56, 1'b1, 1'b1, "R6");
  endtask

  // R7: expected label-only stream
  task automatic push_key();
    string lbl = "Key = ";
    push(8'hC0, 1'b0, 1'b0, "R7");
    for (int i = 0; i < lbl.len(); i++)
      push(lbl[i], 1'b1, i == lbl.len() - 1, "R7");
  endtask

  task automatic pulse(input logic v, input logic k, input int h, input int t, input int o);
    @(posedge clk) #1;
    start_volt = v; start_key = k;
    hun_digit = 4'(h); ten_digit = 4'(t); one_digit = 4'(o);
    @(posedge clk) #1;
    start_volt = 1'b0; start_key = 1'b0;
  endtask

  task automatic drain_and_idle();
    while (exp_q.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R10", "idle out_valid", int'(out_valid), 0);
    end
  endtask

  // Ready driver
  initial begin
    out_ready = 1'b1;
    forever begin
      @(posedge clk) #1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = (ready_mode == 0) ? 1'b1 : (lfsr[0] | lfsr[2]);
    end
  end

  // Scoreboard monitor
  initial begin
    logic prev_last_acc = 1'b0;
    logic prev_stall = 1'b0;
    logic [7:0] prev_b = '0;
    logic prev_rs = 1'b0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (done_pulse || prev_last_acc)  // R9
          check(done_pulse == prev_last_acc, "R9", "done_pulse",
                int'(done_pulse), int'(prev_last_acc));
        if (prev_stall)  // R8
          check(out_valid && out_byte == prev_b && out_rs == prev_rs, "R8",
                "stalled byte held", int'(out_byte), int'(prev_b));
        prev_last_acc = 1'b0;
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R10", "unexpected byte", int'(out_byte), 0);
          end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(out_byte == e.b, e.tag, "byte", int'(out_byte), int'(e.b));
            check(out_rs == e.rs, e.tag, "rs flag", int'(out_rs), int'(e.rs));
            prev_last_acc = e.last;
          end
        end
        prev_stall = out_valid && !out_ready;
        prev_b = out_byte;
        prev_rs = out_rs;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!bench_done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired with %0d bytes outstanding", exp_q.size());
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: idle during and right after reset
    repeat (3) @(negedge clk);
    check(!out_valid && !done_pulse, "R1", "valid/done in reset",
          int'({out_valid, done_pulse}), 0);
    @(posedge clk) #1 rst = 1'b0;
    @(negedge clk);
    check(!out_valid && !done_pulse, "R1", "valid/done after reset",
          int'({out_valid, done_pulse}), 0);

    // Readout, ready always high
    push_volt(3, 4, 7);
    pulse(1, 0, 3, 4, 7);
    drain_and_idle();

    // R7: label request
    push_key();
    pulse(0, 1, 0, 0, 0);
    drain_and_idle();

    // R8: random stalls, digit extremes
    ready_mode = 1;
    push_volt(0, 0, 0);
    pulse(1, 0, 0, 0, 0);
    drain_and_idle();
    push_volt(9, 9, 9);
    pulse(1, 0, 9, 9, 9);
    drain_and_idle();
    push_key();
    pulse(0, 1, 0, 0, 0);
    drain_and_idle();

    // R12: both requests in one cycle, readout wins
    push_volt(2, 6, 1);
    pulse(1, 1, 2, 6, 1);
    drain_and_idle();

    // R10: requests during a sequence are ignored
    push_volt(5, 0, 8);
    pulse(1, 0, 5, 0, 8);
    repeat (4) @(posedge clk);
    pulse(1, 1, 7, 7, 7);
    repeat (3) @(posedge clk);
    pulse(0, 1, 1, 1, 1);
    drain_and_idle();

    // R11: digits change mid-sequence, captured ones are sent
    push_volt(1, 5, 8);
    pulse(1, 0, 1, 5, 8);
    hun_digit = 4'd9; ten_digit = 4'd2; one_digit = 4'd6;
    drain_and_idle();

    // R10: request in the done cycle starts a new sequence
    ready_mode = 0;
    push_volt(4, 2, 0);
    push_key();
    pulse(1, 0, 4, 2, 0);
    do @(negedge clk); while (!done_pulse);
    start_key = 1'b1;
    @(posedge clk) #1 start_key = 1'b0;
    drain_and_idle();

    bench_done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule